// File: doc/BRIEF.md
# Flow-controlled overlay compute tile

This block is the arithmetic tile of a coarse-grained overlay array. Four neighbouring switches sit on its diagonals: south-west, north-west, north-east and south-east. Each of them can hand it a 16-bit datum together with a valid strobe. The tile sends one result, with its own valid strobe, to the switch on its south-east side. A static 16-bit configuration word sets the tile's behaviour. It chooses the operation, names the neighbour that supplies each operand, and can replace the second operand with a small constant held in the word itself.

Each operand has its own one-entry holding slot, run by a two-state machine. The slot is EMPTY or FULL. It moves EMPTY to FULL on a CAPTURE, which is a valid strobe from its selected neighbour. It moves FULL to EMPTY on a CONSUME, which is a launch. Because of these slots, operands can arrive at unrelated times and in either order. On the output side a second machine tracks the credits that the downstream switch has granted. It is OPEN while at least one credit remains and BLOCKED when none remain. It moves OPEN to BLOCKED when the last credit is spent, and BLOCKED to OPEN when a credit comes back.

A launch happens once every needed slot is FULL and the output machine is OPEN. The launch fires a pipelined compute core that has a fixed latency. One cycle later it sends a credit back to each neighbour whose datum it consumed.

Top module: `ovl_fu_tile`

## Requirements
- R1: After reset, `res_valid` and every bit of `nb_credit` are low, and both operand slots are empty, so no result appears until operands arrive.
- R2: `cfg[15:14]` selects the operation on operands A and B, computed modulo 2^16: 0 gives A+B, 1 gives A-B, 2 gives the low 16 bits of A*B, and 3 gives A|B.
- R3: `cfg[12:11]` names the neighbour index that supplies A, and `cfg[10:9]` names the neighbour index that supplies B. The indices are 0 south-west, 1 north-west, 2 north-east and 3 south-east, and they select bits of `nb_valid`, `nb_credit` and words of `nb_data`.
- R4: When `cfg[13]` is 1, B is `cfg[8:0]` zero-extended. Valid strobes on B's neighbour are then ignored: nothing is captured and no credit is returned to that neighbour.
- R5: A launch waits until A is held, B is held or constant, and output credit is available. The two operands may arrive in either order and with any gap between them.
- R6: If a launch happens in cycle c, `res_valid` is high for exactly cycle c+LAT (default LAT=3), with the result on `res_data`.
- R7: In the cycle after a launch, `nb_credit` is high for one cycle on every neighbour whose datum was consumed. When A and B name the same neighbour, one datum feeds both operands and a single credit pulse is returned.
- R8: The output starts with OUT_CREDITS credits (default 2). Each launch spends one credit and each `res_credit` pulse restores one. With no credit left, operands are held unconsumed and no further result appears.
- R9: Valid strobes on a neighbour that neither operand selects are ignored: no capture, no credit returned, no change to results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg | input | 16 | Static configuration word: operation, operand sources, constant select and constant |
| nb_data | input | 4x16 | Data word from each neighbour (index 0 SW, 1 NW, 2 NE, 3 SE) |
| nb_valid | input | 4 | Valid strobe from each neighbour |
| nb_credit | output | 4 | One-cycle credit return to each neighbour |
| res_data | output | 16 | Result word to the south-east switch |
| res_valid | output | 1 | Result valid strobe |
| res_credit | input | 1 | Credit pulse from the south-east switch |

## Verification
Suppose an operand slot is stuck FULL or stuck EMPTY. The tile would then either launch a second time on a stale operand or never launch at all. At the ports this shows up as a wrong or missing `res_data`, within LAT cycles of the second operand's arrival. A lost credit pulse, or a credit sent to the wrong neighbour, shows up in the bench's per-neighbour credit tally one cycle after the launch. That wrong tally then starves or overfeeds the next transfer on that neighbour. A bad output-credit count shows up as a result that appears while the bench is deliberately withholding `res_credit`, or as no result after a credit has been given back.

// File: rtl/ovl_fu_pkg.sv
package ovl_fu_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_OR  = 2'd3
    } fu_op_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_st_e;

    typedef enum logic {
        OUT_OPEN    = 1'b0,
        OUT_BLOCKED = 1'b1
    } out_st_e;

    // configuration field positions
    localparam int CFG_OP_LSB    = 14;
    localparam int CFG_KSEL_BIT  = 13;
    localparam int CFG_ASEL_LSB  = 11;
    localparam int CFG_BSEL_LSB  = 9;
    localparam int CFG_CONST_W   = 9;
endpackage

// File: rtl/ovl_fu_slot.sv
module ovl_fu_slot
    import ovl_fu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_valid,
    input  logic [DW-1:0] cap_data,
    input  logic          consume,
    output logic          full,
    output logic [DW-1:0] data
);
    slot_st_e      state_q, state_d;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (cap_valid) state_d = SLOT_FULL;
            SLOT_FULL:  if (consume)   state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                data_q <= '0;
        else if (state_q == SLOT_EMPTY && cap_valid) data_q <= cap_data;
    end

    assign full = (state_q == SLOT_FULL);
    assign data = data_q;

    // R5
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_FULL && !consume) |=> (state_q == SLOT_FULL && $stable(data_q)));
    // R7
    slot_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> (state_q == SLOT_EMPTY));
endmodule

// File: rtl/ovl_fu_launch.sv
module ovl_fu_launch
    import ovl_fu_pkg::*;
#(
    parameter int OUT_CREDITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a_full,
    input  logic b_full,
    input  logic b_const,
    input  logic res_credit,
    output logic launch
);
    localparam int CW = $clog2(OUT_CREDITS + 1);
    localparam logic [CW-1:0] CMAX = CW'(OUT_CREDITS);

    out_st_e       st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= (OUT_CREDITS > 0) ? OUT_OPEN : OUT_BLOCKED;
            cnt_q <= CMAX;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        launch = 1'b0;
        unique case (st_q)
            OUT_OPEN:    launch = a_full && (b_const || b_full);
            OUT_BLOCKED: launch = 1'b0;
        endcase
        cnt_d = cnt_q - CW'(launch) + CW'(res_credit);
        st_d  = (cnt_d == '0) ? OUT_BLOCKED : OUT_OPEN;
    end

    // R8
    credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CMAX);
    // R8
    credit_spend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !res_credit) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/ovl_fu_core.sv
module ovl_fu_core
    import ovl_fu_pkg::*;
#(
    parameter int DW  = 16,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  fu_op_e        op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    logic [DW-1:0] r;
    logic [LAT-1:0] vq;
    logic [DW-1:0]  dq [LAT];

    always_comb begin
        unique case (op)
            OP_ADD: r = a + b;
            OP_SUB: r = a - b;
            OP_MUL: r = a * b;
            OP_OR:  r = a | b;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vq[0] <= 1'b0;
            dq[0] <= '0;
        end else begin
            vq[0] <= go;
            dq[0] <= r;
        end
    end

    for (genvar g = 1; g < LAT; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vq[g] <= 1'b0;
                dq[g] <= '0;
            end else begin
                vq[g] <= vq[g-1];
                dq[g] <= dq[g-1];
            end
        end
    end

    assign out_valid = vq[LAT-1];
    assign out_data  = dq[LAT-1];
endmodule

// File: rtl/ovl_fu_tile.sv
module ovl_fu_tile
    import ovl_fu_pkg::*;
#(
    parameter int DW          = 16,
    parameter int LAT         = 3,
    parameter int OUT_CREDITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [15:0]         cfg,
    input  logic [3:0][DW-1:0]  nb_data,
    input  logic [3:0]          nb_valid,
    output logic [3:0]          nb_credit,
    output logic [DW-1:0]       res_data,
    output logic                res_valid,
    input  logic                res_credit
);
    fu_op_e        op;
    logic [1:0]    a_sel, b_sel;
    logic          b_const;
    logic [DW-1:0] k_val;
    logic          a_full, b_full, launch;
    logic [DW-1:0] a_val, b_slot, b_val;
    logic [3:0]    credit_q;

    assign op      = fu_op_e'(cfg[CFG_OP_LSB +: 2]);
    assign b_const = cfg[CFG_KSEL_BIT];
    assign a_sel   = cfg[CFG_ASEL_LSB +: 2];
    assign b_sel   = cfg[CFG_BSEL_LSB +: 2];
    assign k_val   = {{(DW-CFG_CONST_W){1'b0}}, cfg[CFG_CONST_W-1:0]};

    ovl_fu_slot #(.DW(DW)) u_slot_a (
        .clk(clk), .rst_n(rst_n),
        .cap_valid(nb_valid[a_sel]), .cap_data(nb_data[a_sel]),
        .consume(launch), .full(a_full), .data(a_val)
    );

    ovl_fu_slot #(.DW(DW)) u_slot_b (
        .clk(clk), .rst_n(rst_n),
        .cap_valid(nb_valid[b_sel] && !b_const), .cap_data(nb_data[b_sel]),
        .consume(launch && !b_const), .full(b_full), .data(b_slot)
    );

    assign b_val = b_const ? k_val : b_slot;

    ovl_fu_launch #(.OUT_CREDITS(OUT_CREDITS)) u_launch (
        .clk(clk), .rst_n(rst_n),
        .a_full(a_full), .b_full(b_full), .b_const(b_const),
        .res_credit(res_credit), .launch(launch)
    );

    ovl_fu_core #(.DW(DW), .LAT(LAT)) u_core (
        .clk(clk), .rst_n(rst_n), .go(launch), .op(op),
        .a(a_val), .b(b_val), .out_valid(res_valid), .out_data(res_data)
    );

    for (genvar i = 0; i < 4; i++) begin : g_credit
        always_ff @(posedge clk) begin
            if (!rst_n) credit_q[i] <= 1'b0;
            else        credit_q[i] <= launch &&
                        ((a_sel == 2'(i)) || (!b_const && b_sel == 2'(i)));
        end
    end

    assign nb_credit = credit_q;

    // R7
    credit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|nb_credit) |-> $past(launch));
    // R7
    credit_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(nb_credit) <= 2);
endmodule

// File: tb/ovl_fu_tile_bench.sv
module ovl_fu_tile_bench;
    localparam int DW = 16;
    localparam int LAT = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       cfg = '0;
    logic [3:0][DW-1:0] nb_data = '0;
    logic [3:0]        nb_valid = '0;
    logic [3:0]        nb_credit;
    logic [DW-1:0]     res_data;
    logic              res_valid;
    logic              res_credit = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cred [4];
    bit auto_ret = 1'b1;
    bit got_res = 1'b0;
    logic [DW-1:0] last_res = '0;
    logic [3:0] cr_seen = '0;

    ovl_fu_tile #(.DW(DW), .LAT(LAT), .OUT_CREDITS(2)) u_ovl_fu_tile (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .nb_data(nb_data),
        .nb_valid(nb_valid), .nb_credit(nb_credit), .res_data(res_data),
        .res_valid(res_valid), .res_credit(res_credit)
    );

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] calc(logic [1:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
        case (op)
            2'd0: return a + b;
            2'd1: return a - b;
            2'd2: return a * b;
            default: return a | b;
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cr_seen = nb_credit;
        if (res_valid) begin
            got_res = 1'b1;
            last_res = res_data;
        end
        for (int p = 0; p < 4; p++) if (nb_credit[p]) cred[p]++;
        nb_valid = '0;
        res_credit = auto_ret && res_valid;
    endtask

    task automatic send(int p, logic [DW-1:0] d);
        while (cred[p] == 0) tick();
        cred[p]--;
        nb_data[p] = d;
        nb_valid[p] = 1'b1;
        tick();
    endtask

    task automatic wait_res(int lim);
        for (int i = 0; i < lim && !got_res; i++) tick();
    endtask

    function automatic logic [15:0] mkcfg(logic [1:0] op, bit k, logic [1:0] as, logic [1:0] bs, logic [8:0] c);
        return {op, k, as, bs, c};
    endfunction

    initial begin
        #(200000 * 10);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0f11));
        for (int p = 0; p < 4; p++) cred[p] = 1;
        cfg = mkcfg(2'd0, 1'b1, 2'd0, 2'd0, 9'd3);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
        chk(nb_credit == 4'b0, "R1 nb_credit", nb_credit, 0);
        got_res = 1'b0;
        repeat (6) tick();
        // R1 R5 no launch without operand A
        chk(!got_res, "R1/R5 spurious result", got_res, 0);

        // R6 R7 directed latency: B from NE(2), A from SW(0)
        cfg = mkcfg(2'd0, 1'b0, 2'd0, 2'd2, 9'd0);
        send(2, 16'd5);
        tick(); tick();
        cred[0]--;
        nb_data[0] = 16'd7;
        nb_valid[0] = 1'b1;
        tick();
        chk(!got_res, "R6 early result", got_res, 0);
        tick();
        chk(cr_seen == 4'b0101, "R7 credit pulse", cr_seen, 4'b0101);
        tick();
        chk(!got_res && cr_seen == 4'b0, "R6/R7 cycle c+2", {got_res, cr_seen}, 0);
        tick();
        chk(got_res && last_res == 16'd12, "R6 result at c+LAT", last_res, 12);
        got_res = 1'b0;
        tick();
        chk(!got_res, "R6 single-cycle valid", got_res, 0);

        // R4 constant with junk on B neighbour
        cfg = mkcfg(2'd3, 1'b1, 2'd1, 2'd3, 9'h1F0);
        got_res = 1'b0;
        nb_data[3] = 16'hFFFF;
        nb_valid[3] = 1'b1;
        tick();
        send(1, 16'h000F);
        wait_res(20);
        chk(got_res && last_res == 16'h01FF, "R4 constant operand", last_res, 16'h01FF);
        tick(); tick();
        chk(cred[3] == 1, "R4 no credit to B neighbour", cred[3], 1);
        chk(cred[1] == 1, "R7 credit to A neighbour", cred[1], 1);

        // random mix: R2 R3 R5 R7 R9
        for (int it = 0; it < 60; it++) begin
            logic [1:0] op, as, bs;
            bit k, a_first;
            logic [8:0] c;
            logic [DW-1:0] a, b, be, exp;
            int jp, jc;
            op = 2'($urandom % 4);
            as = 2'($urandom % 4);
            bs = 2'($urandom % 4);
            k = ($urandom % 4) == 0;
            c = 9'($urandom);
            a = 16'($urandom);
            b = 16'($urandom);
            a_first = $urandom % 2;
            cfg = mkcfg(op, k, as, bs, c);
            be = k ? {7'd0, c} : ((as == bs) ? a : b);
            exp = calc(op, a, be);
            jp = -1;
            for (int p = 0; p < 4; p++)
                if (p != int'(as) && (k || p != int'(bs))) jp = p;
            jc = (jp >= 0) ? cred[jp] : 0;
            got_res = 1'b0;
            if (jp >= 0) begin
                nb_data[jp] = 16'($urandom);
                nb_valid[jp] = 1'b1;
                tick();
            end
            if (k || as == bs) send(int'(as), a);
            else if (a_first) begin
                send(int'(as), a);
                repeat ($urandom % 5) tick();
                send(int'(bs), b);
            end else begin
                send(int'(bs), b);
                repeat ($urandom % 5) tick();
                send(int'(as), a);
            end
            wait_res(40);
            // R2 R3 R5
            chk(got_res && last_res == exp, "R2/R3/R5 result", last_res, exp);
            tick(); tick();
            // R7
            chk(cred[as] == 1 && cred[bs] == 1, "R7 credits restored",
                cred[as] * 16 + cred[bs], 16'h11);
            // R9
            if (jp >= 0) chk(cred[jp] == jc, "R9 unselected ignored", cred[jp], jc);
        end

        // R8 output credit stall
        auto_ret = 1'b0;
        cfg = mkcfg(2'd0, 1'b1, 2'd1, 2'd0, 9'd1);
        got_res = 1'b0;
        send(1, 16'd10);
        wait_res(20);
        chk(got_res && last_res == 16'd11, "R8 first result", last_res, 11);
        got_res = 1'b0;
        send(1, 16'd20);
        wait_res(20);
        chk(got_res && last_res == 16'd21, "R8 second result", last_res, 21);
        got_res = 1'b0;
        send(1, 16'd30);
        repeat (15) tick();
        chk(!got_res, "R8 stall without credit", got_res, 0);
        chk(cred[1] == 0, "R8 operand held", cred[1], 0);
        res_credit = 1'b1;
        tick();
        wait_res(20);
        chk(got_res && last_res == 16'd31, "R8 resume after credit", last_res, 31);
        tick(); tick();
        chk(cred[1] == 1, "R8 credit after resume", cred[1], 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule